// File: doc/BRIEF.md
# Receiver Idle Timeout Controller

This block measures how long a serial receive line stays quiet after a character has arrived. Time is counted in bit periods, marked by a one-cycle tick from the baud generator. When the programmed number of bit periods passes with no further character, a sticky timeout flag is raised. The counter then stops until software acts again. Software uses the flag to detect the end of a burst of received data of unknown length.

Two command strobes restart the measurement in different ways:

- **Arm.** Clears the flag, drops any period in progress, and waits for the next received character before counting begins.
- **Immediate restart.** Reloads the counter and begins counting at once, with no character needed.

A programmed value of zero turns the function off. Recognising characters on the line is done elsewhere. This block only sees a pulse per received character.

Top module: `rxIdleTimeout`

## Requirements
- R1: After reset the timeout flag is 0 and busy is 0, and the block is armed and waiting for a character.
- R2: While armed, bit-period ticks are not counted: busy stays 0 and the flag does not rise.
- R3: A character pulse while armed loads the programmed value N and sets busy the following cycle. The flag is 1 and busy is 0 in the cycle after the N-th tick that follows the character, and not earlier.
- R4: A character pulse while counting reloads N, so a further N ticks are needed. When a character pulse and a tick fall in the same cycle, the reload wins and that tick is not counted.
- R5: The flag is sticky. After expiry, busy stays 0 and neither ticks nor character pulses restart counting or clear the flag.
- R6: An arm strobe (without restart) clears the flag and cancels any period in progress: in the next cycle flag and busy are both 0, and counting resumes only after a character.
- R7: A restart strobe with N nonzero loads N and sets busy the next cycle with no character needed. The flag rises after N further ticks. Restart leaves an already set flag unchanged.
- R8: With N = 0 the function is off. Busy is 0 from the next cycle, even if a period was running. Characters, ticks and restart strobes never start counting or set the flag. An arm strobe still clears the flag.
- R9: When arm and restart arrive in the same cycle, restart wins and arm is ignored. The flag keeps its value, and with N nonzero counting starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One pulse per receive bit period |
| charRcvd | input | 1 | One pulse per received character |
| armCmd | input | 1 | Clear flag and wait for next character |
| restartCmd | input | 1 | Reload and start counting now |
| timeoutVal | input | COUNT_W | Timeout in bit periods, 0 disables |
| timeoutFlag | output | 1 | Sticky timeout indication |
| busy | output | 1 | Counter is running |

## Verification
Two pairs of events can coincide in one cycle:

- **Character pulse and tick during counting.** The bench drives both together partway through a period. It then expects exactly N more ticks before the flag, not N-1.
- **Arm and restart together.** The bench first lets the flag set, then applies both strobes. It expects the flag to survive and busy to rise, showing that restart took priority.

Every timeout value of a 4-bit configuration is swept. Expected flag timing is derived arithmetically from N and the number of ticks applied.

// File: rtl/rxIdlePkg.sv
package rxIdlePkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_COUNT = 2'd1,
    ST_STOP  = 2'd2
  } idleState_t;

  typedef struct packed {
    logic load;
    logic dec;
    logic clear;
  } cntStrobe_t;
endpackage

// File: rtl/rxIdleCnt.sv
module rxIdleCnt #(
  parameter int COUNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  rxIdlePkg::cntStrobe_t  strobe,
  input  logic [COUNT_W-1:0]     loadVal,
  output logic                   countIsOne
);
  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  logic [COUNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.load) begin
      count <= loadVal;
    end else if (strobe.clear) begin
      count <= '0;
    end else if (strobe.dec) begin
      count <= count - ONE;
    end
  end

  assign countIsOne = (count == ONE);
endmodule

// File: rtl/rxIdleCtl.sv
module rxIdleCtl #(
  parameter int COUNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   bitTick,
  input  logic                   charRcvd,
  input  logic                   armCmd,
  input  logic                   restartCmd,
  input  logic [COUNT_W-1:0]     timeoutVal,
  input  logic                   countIsOne,
  output rxIdlePkg::cntStrobe_t  strobe,
  output logic                   timeoutFlag,
  output logic                   busy
);
  import rxIdlePkg::*;

  idleState_t state, stateNxt;
  logic       flagNxt;
  logic       cfgOff;

  assign cfgOff = (timeoutVal == '0);

  always_comb begin
    stateNxt = state;
    flagNxt  = timeoutFlag;
    strobe   = '0;
    if (restartCmd) begin
      // restart has priority over arm
      if (!cfgOff) begin
        strobe.load = 1'b1;
        stateNxt    = ST_COUNT;
      end else if (state == ST_COUNT) begin
        strobe.clear = 1'b1;
        stateNxt     = ST_ARMED;
      end
    end else if (armCmd) begin
      strobe.clear = 1'b1;
      stateNxt     = ST_ARMED;
      flagNxt      = 1'b0;
    end else if (cfgOff) begin
      if (state == ST_COUNT) begin
        strobe.clear = 1'b1;
        stateNxt     = ST_ARMED;
      end
    end else begin
      unique case (state)
        ST_ARMED: begin
          if (charRcvd) begin
            strobe.load = 1'b1;
            stateNxt    = ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (charRcvd) begin
            strobe.load = 1'b1;
          end else if (bitTick) begin
            if (countIsOne) begin
              strobe.clear = 1'b1;
              stateNxt     = ST_STOP;
              flagNxt      = 1'b1;
            end else begin
              strobe.dec = 1'b1;
            end
          end
        end
        ST_STOP: begin
          stateNxt = ST_STOP;
        end
        default: begin
          strobe.clear = 1'b1;
          stateNxt     = ST_ARMED;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_ARMED;
      timeoutFlag <= 1'b0;
    end else begin
      state       <= stateNxt;
      timeoutFlag <= flagNxt;
    end
  end

  assign busy = (state == ST_COUNT);
endmodule

// File: rtl/rxIdleTimeout.sv
module rxIdleTimeout #(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitTick,
  input  logic               charRcvd,
  input  logic               armCmd,
  input  logic               restartCmd,
  input  logic [COUNT_W-1:0] timeoutVal,
  output logic               timeoutFlag,
  output logic               busy
);
  rxIdlePkg::cntStrobe_t cntStrobe;
  logic                  countIsOne;

  rxIdleCtl #(.COUNT_W(COUNT_W)) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .bitTick    (bitTick),
    .charRcvd   (charRcvd),
    .armCmd     (armCmd),
    .restartCmd (restartCmd),
    .timeoutVal (timeoutVal),
    .countIsOne (countIsOne),
    .strobe     (cntStrobe),
    .timeoutFlag(timeoutFlag),
    .busy       (busy)
  );

  rxIdleCnt #(.COUNT_W(COUNT_W)) uCnt (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (cntStrobe),
    .loadVal   (timeoutVal),
    .countIsOne(countIsOne)
  );
endmodule

// File: rtl/rxIdleTimeoutChk.sv
module rxIdleTimeoutChk #(
  parameter int COUNT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               bitTick,
  input logic               charRcvd,
  input logic               armCmd,
  input logic               restartCmd,
  input logic [COUNT_W-1:0] timeoutVal,
  input logic               timeoutFlag,
  input logic               busy
);
  assert_flag_rise_after_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> ($past(busy) && $past(bitTick) && !$past(charRcvd)));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !(armCmd && !restartCmd)) |=> timeoutFlag);

  assert_arm_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armCmd && !restartCmd) |=> (!timeoutFlag && !busy));

  assert_restart_starts_R7: assert property (@(posedge clk) disable iff (!rstN)
    (restartCmd && (timeoutVal != '0)) |=> busy);

  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutVal == '0) |=> !busy);

  assert_disabled_no_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((timeoutVal == '0) && !timeoutFlag) |=> !timeoutFlag);

  assert_busy_flag_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && $rose(timeoutFlag)));
endmodule

bind rxIdleTimeout rxIdleTimeoutChk #(.COUNT_W(COUNT_W)) uChk (.*);

// File: tb/sim_rxIdleTimeout.sv
module sim_rxIdleTimeout;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         bitTick = 1'b0;
  logic         charRcvd = 1'b0;
  logic         armCmd = 1'b0;
  logic         restartCmd = 1'b0;
  logic [W-1:0] timeoutVal = '0;
  logic         timeoutFlag;
  logic         busy;

  int  vecCount = 0;
  int  missCount = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  rxIdleTimeout #(.COUNT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .charRcvd(charRcvd),
    .armCmd(armCmd), .restartCmd(restartCmd), .timeoutVal(timeoutVal),
    .timeoutFlag(timeoutFlag), .busy(busy)
  );

  // one clock cycle: inputs set at negedge, outputs sampled at following negedge
  task automatic cyc(input logic tk, input logic ch, input logic ar, input logic rs);
    bitTick = tk; charRcvd = ch; armCmd = ar; restartCmd = rs;
    @(posedge clk);
    @(negedge clk);
    bitTick = 1'b0; charRcvd = 1'b0; armCmd = 1'b0; restartCmd = 1'b0;
  endtask

  task automatic expect2(input logic expFlag, input logic expBusy, input string tag);
    vecCount++;
    if (timeoutFlag !== expFlag || busy !== expBusy) begin
      missCount++;
      $display("FAIL %s: flag/busy actual %b/%b expected %b/%b",
               tag, timeoutFlag, busy, expFlag, expBusy);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    expect2(1'b0, 1'b0, "R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    expect2(1'b0, 1'b0, "R1 after reset release");

    // R2: ticks while armed do nothing
    timeoutVal = 4'd2;
    for (int i = 0; i < 5; i++) begin
      cyc(1, 0, 0, 0);
      expect2(1'b0, 1'b0, "R2 armed tick ignored");
    end

    // R3 sweep over every nonzero value
    for (int n = 1; n <= MAXV; n++) begin
      timeoutVal = W'(n);
      cyc(0, 0, 1, 0);
      expect2(1'b0, 1'b0, "R6 arm before sweep");
      cyc(0, 1, 0, 0);
      expect2(1'b0, 1'b1, "R3 char starts");
      for (int k = 1; k <= n; k++) begin
        cyc(1, 0, 0, 0);
        if (k < n) expect2(1'b0, 1'b1, "R3 counting");
        else       expect2(1'b1, 1'b0, "R3 expiry after N ticks");
        cyc(0, 0, 0, 0);
        if (k < n) expect2(1'b0, 1'b1, "R3 idle cycle holds");
        else       expect2(1'b1, 1'b0, "R5 flag holds");
      end
      // R5: after expiry nothing restarts
      cyc(0, 1, 0, 0);
      expect2(1'b1, 1'b0, "R5 char after expiry ignored");
      cyc(1, 0, 0, 0);
      expect2(1'b1, 1'b0, "R5 tick after expiry ignored");
    end

    // R4 reload by char, and char+tick same cycle
    for (int n = 2; n <= 6; n++) begin
      timeoutVal = W'(n);
      cyc(0, 0, 1, 0);
      cyc(0, 1, 0, 0);
      for (int k = 0; k < n - 1; k++) cyc(1, 0, 0, 0);
      expect2(1'b0, 1'b1, "R4 one tick left");
      cyc(1, 1, 0, 0);   // reload wins over tick
      expect2(1'b0, 1'b1, "R4 char+tick reloads");
      for (int k = 1; k <= n; k++) begin
        cyc(1, 0, 0, 0);
        if (k < n) expect2(1'b0, 1'b1, "R4 full period after reload");
        else       expect2(1'b1, 1'b0, "R4 expiry after reload");
      end
    end

    // R6 arm cancels running period
    timeoutVal = 4'd3;
    cyc(0, 0, 1, 0);
    expect2(1'b0, 1'b0, "R6 arm clears flag");
    cyc(0, 1, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 0);
    expect2(1'b0, 1'b0, "R6 arm cancels period");
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0);
    expect2(1'b0, 1'b0, "R6 waits for char");

    // R7 immediate restart, from armed and with flag set
    for (int n = 1; n <= 5; n++) begin
      timeoutVal = W'(n);
      cyc(0, 0, 1, 0);
      cyc(0, 0, 0, 1);
      expect2(1'b0, 1'b1, "R7 restart starts now");
      for (int k = 1; k <= n; k++) begin
        cyc(1, 0, 0, 0);
        if (k < n) expect2(1'b0, 1'b1, "R7 counting");
        else       expect2(1'b1, 1'b0, "R7 expiry");
      end
      cyc(0, 0, 0, 1);
      expect2(1'b1, 1'b1, "R7 restart keeps flag");
      // R9 both strobes: restart wins, flag kept
      cyc(0, 0, 1, 1);
      expect2(1'b1, 1'b1, "R9 restart beats arm");
      for (int k = 0; k < n; k++) cyc(1, 0, 0, 0);
      expect2(1'b1, 1'b0, "R9 period completes");
    end

    // R8 zero disables
    timeoutVal = 4'd3;
    cyc(0, 0, 1, 0);
    cyc(0, 1, 0, 0);
    expect2(1'b0, 1'b1, "R8 pre running");
    timeoutVal = 4'd0;
    cyc(0, 0, 0, 0);
    expect2(1'b0, 1'b0, "R8 zero stops period");
    cyc(0, 1, 0, 0);
    expect2(1'b0, 1'b0, "R8 char ignored");
    cyc(0, 0, 0, 1);
    expect2(1'b0, 1'b0, "R8 restart ignored");
    for (int k = 0; k < 20; k++) cyc(1, k[0], 0, 0);
    expect2(1'b0, 1'b0, "R8 no flag");
    timeoutVal = 4'd1;
    cyc(0, 0, 0, 1);
    cyc(1, 0, 0, 0);
    expect2(1'b1, 1'b0, "R8 set flag for clear test");
    timeoutVal = 4'd0;
    cyc(0, 0, 1, 0);
    expect2(1'b0, 1'b0, "R8 arm clears while off");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule